// File: doc/BRIEF.md
# Serial Interrupt Host Frame Controller

This block is the host end of a one-wire serial interrupt bus that runs on the PCI clock. The line is shared and open-drain. The host pulls it low for the start frame and for the stop frame. Between those two frames it samples the line once in each data slot. A low level in slot N is reported as an active request on `irq_req[N]`. An 8-bit control register sets four things: whether the function is on, which of two modes it runs in, how many data slots a cycle has, and how wide the start pulse is.

In continuous mode the host opens every cycle by itself, one idle clock after the previous stop frame. In quiet mode the host stays idle until a peripheral pulls the line low. The host then drives the remaining clocks of the start pulse, which is one clock shorter than the programmed width. The first cycle after reset always runs with continuous behaviour, so that quiet operation has a defined starting point.

Each data slot lasts three clocks: sample, recovery and turnaround. The slot count is a fixed base of 17 plus the 4-bit frame-count code. The top-level output is an open-drain enable, `sirq_oe`. When it is 1 the pad pulls the line low.

Top module: `sirq_host`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x10, `sirq_oe` is 0 and every bit of `irq_req` is 0.
- R2: A cycle with `cfg_wr_en` high loads all eight bits of `cfg_wr_data` into the control register. The new value is readable on the next clock. Without a write the value holds.
- R3: While bit 7 (enable) is 0, the block never drives the line, every bit of `irq_req` reads 0, and a low line has no effect. Clearing bit 7 during a cycle aborts that cycle at once.
- R4: With bit 6 = 1 (continuous mode), each cycle opens with a host start pulse. Its length depends on bits 1:0: code 0 gives 4 clocks, 1 gives 6, 2 gives 8, and 3 falls back to 4. The next start pulse begins after exactly one idle clock following the stop frame.
- R5: With bit 6 = 0 (quiet mode), once the forced first cycle is over, the host does not start a cycle until it sees the line low while idle. It then drives the start pulse for the programmed width minus one clock.
- R6: The first cycle after reset runs with continuous behaviour even when bit 6 is 0: the host starts it unprompted with the full-width pulse.
- R7: A cycle has 17 + bits 5:2 data slots. The start pulse is followed by two released clocks. Slot k is then sampled 2 + 3k clocks after the first released clock. `irq_req[k]` becomes 1 if the line was low in that clock and 0 if it was high. Bits at or above the slot count are not updated.
- R8: The stop frame pulls the line low for 3 clocks when bit 6 is 1 and for 2 clocks when bit 6 is 0.
- R9: In continuous mode, a line pulled low by a peripheral during the idle clock does not shorten the host start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write value |
| cfg_rd_data | output | 8 | Control register contents |
| sirq_in | input | 1 | Level seen on the shared serial interrupt line |
| sirq_oe | output | 1 | 1 = pull the shared line low |
| irq_req | output | BASE_FRAMES+15 | Latched request per slot, 1 = requesting |

## Verification
The case to watch is the host's own start decision and a peripheral's start signal landing in the same clock. In continuous mode the bench pulls the line low during the single idle clock that comes before a host start. It then measures the start pulse to confirm it still has the full programmed width and was not shortened as a quiet-mode start would be. The same cycle-length count also covers the reverse overlap: the forced continuous first cycle while the mode bit already selects quiet. There the bench expects a full-width start and a two-clock stop in the same cycle.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int unsigned CFG_W        = 8;
  localparam int unsigned FRM_CODE_W   = 4;
  localparam int unsigned CNT_W        = 4;
  localparam int unsigned TURN_CLKS    = 2;
  localparam int unsigned SLOT_PHASES  = 3;
  localparam int unsigned STOP_CONT    = 3;
  localparam int unsigned STOP_QUIET   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_TURN,
    ST_SLOT,
    ST_STOP
  } seq_state_t;

  typedef struct packed {
    logic                  en;
    logic                  cont;
    logic [FRM_CODE_W-1:0] frm;
    logic [1:0]            pw;
  } sirq_cfg_t;

  // Start-pulse width in clocks; the reserved code falls back to the narrowest
  function automatic logic [CNT_W-1:0] start_clocks(input logic [1:0] code);
    case (code)
      2'b01:   return CNT_W'(6);
      2'b10:   return CNT_W'(8);
      default: return CNT_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/sirq_rst_sync.sv
module sirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/sirq_cfg_reg.sv
module sirq_cfg_reg
  import sirq_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VAL = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output sirq_cfg_t        cfg
);

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= RESET_VAL;
    else if (wr_en) cfg_q <= wr_data;
  end

  assign cfg = sirq_cfg_t'(cfg_q);

endmodule

// File: rtl/sirq_seq.sv
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int unsigned BASE_FRAMES = 17,
  parameter int unsigned SLOT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sirq_cfg_t         cfg,
  input  logic              line,
  output logic              drive_low,
  output logic              sample_stb,
  output logic [SLOT_W-1:0] slot_idx
);

  localparam logic [1:0] PH_LAST = 2'(SLOT_PHASES - 1);

  seq_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [1:0]        ph_q, ph_d;
  logic              seen_q, seen_d;   // a complete cycle has run since reset
  logic              cont_eff;
  logic [SLOT_W-1:0] last_slot;

  assign cont_eff  = cfg.cont | ~seen_q;
  assign last_slot = SLOT_W'(BASE_FRAMES - 1) + SLOT_W'(cfg.frm);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    ph_d   = ph_q;
    seen_d = seen_q;
    if (!cfg.en) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      slot_d = '0;
      ph_d   = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (cont_eff) begin
            st_d  = ST_START;
            cnt_d = start_clocks(cfg.pw) - CNT_W'(1);
          end else if (!line) begin
            // peripheral already supplied the first low clock
            st_d  = ST_START;
            cnt_d = start_clocks(cfg.pw) - CNT_W'(2);
          end
        end
        ST_START: begin
          if (cnt_q == '0) begin
            st_d  = ST_TURN;
            cnt_d = CNT_W'(TURN_CLKS - 1);
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        ST_TURN: begin
          if (cnt_q == '0) begin
            st_d   = ST_SLOT;
            slot_d = '0;
            ph_d   = '0;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        ST_SLOT: begin
          if (ph_q == PH_LAST) begin
            ph_d = '0;
            if (slot_q >= last_slot) begin
              st_d  = ST_STOP;
              cnt_d = cfg.cont ? CNT_W'(STOP_CONT - 1) : CNT_W'(STOP_QUIET - 1);
            end else begin
              slot_d = slot_q + SLOT_W'(1);
            end
          end else begin
            ph_d = ph_q + 2'd1;
          end
        end
        ST_STOP: begin
          if (cnt_q == '0) begin
            st_d   = ST_IDLE;
            seen_d = 1'b1;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      slot_q <= '0;
      ph_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      ph_q   <= ph_d;
      seen_q <= seen_d;
    end
  end

  assign drive_low  = cfg.en & ((st_q == ST_START) | (st_q == ST_STOP));
  assign sample_stb = (st_q == ST_SLOT) & (ph_q == 2'd0);
  assign slot_idx   = slot_q;

endmodule

// File: rtl/sirq_slot_latch.sv
module sirq_slot_latch #(
  parameter int unsigned MAX_SLOTS = 32,
  parameter int unsigned SLOT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 sample_stb,
  input  logic [SLOT_W-1:0]    slot_idx,
  input  logic                 line,
  output logic [MAX_SLOTS-1:0] irq_req
);

  for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_slot
    logic hit;
    logic req_q;

    assign hit = sample_stb & (slot_idx == SLOT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   req_q <= 1'b0;
      else if (!en) req_q <= 1'b0;
      else if (hit) req_q <= ~line;
    end

    assign irq_req[i] = req_q;
  end

endmodule

// File: rtl/sirq_host.sv
module sirq_host
  import sirq_pkg::*;
#(
  parameter int unsigned      BASE_FRAMES = 17,
  parameter logic [CFG_W-1:0] CFG_RESET   = 8'h10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr_en,
  input  logic [CFG_W-1:0]        cfg_wr_data,
  output logic [CFG_W-1:0]        cfg_rd_data,
  input  logic                    sirq_in,
  output logic                    sirq_oe,
  output logic [BASE_FRAMES+14:0] irq_req
);

  localparam int unsigned MAX_SLOTS = BASE_FRAMES + (1 << FRM_CODE_W) - 1;
  localparam int unsigned SLOT_W    = $clog2(MAX_SLOTS);

  logic              rst_n_sync;
  sirq_cfg_t         cfg;
  logic              line_eff;
  logic              sample_stb;
  logic [SLOT_W-1:0] slot_idx;

  sirq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  sirq_cfg_reg #(.RESET_VAL(CFG_RESET)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg     (cfg)
  );

  assign cfg_rd_data = cfg;
  // a disabled function sees a permanently idle (high) line
  assign line_eff    = cfg.en ? sirq_in : 1'b1;

  sirq_seq #(.BASE_FRAMES(BASE_FRAMES), .SLOT_W(SLOT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .cfg        (cfg),
    .line       (line_eff),
    .drive_low  (sirq_oe),
    .sample_stb (sample_stb),
    .slot_idx   (slot_idx)
  );

  sirq_slot_latch #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .en         (cfg.en),
    .sample_stb (sample_stb),
    .slot_idx   (slot_idx),
    .line       (line_eff),
    .irq_req    (irq_req)
  );

endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk #(
  parameter int unsigned MAX_SLOTS = 32
) (
  input logic                 clk,
  input logic                 rst_n_sync,
  input logic                 cfg_wr_en,
  input logic [7:0]           cfg_wr_data,
  input logic [7:0]           cfg_rd_data,
  input logic                 sirq_oe,
  input logic [MAX_SLOTS-1:0] irq_req
);

  logic [3:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  low_run_q <= 4'd0;
    else if (sirq_oe) low_run_q <= (low_run_q == 4'd15) ? low_run_q : low_run_q + 4'd1;
    else              low_run_q <= 4'd0;
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cfg_wr_en |=> (cfg_rd_data == $past(cfg_wr_data)));

  a_r2_value_holds: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !cfg_wr_en |=> $stable(cfg_rd_data));

  a_r3_off_no_drive: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !cfg_rd_data[7] |-> !sirq_oe);

  a_r3_off_clears: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !cfg_rd_data[7] |=> (irq_req == '0));

  a_r4_drive_bounded: assert property (@(posedge clk) disable iff (!rst_n_sync)
    low_run_q <= 4'd8);

  a_r7_update_when_released: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !$stable(irq_req) |-> !sirq_oe);

endmodule

bind sirq_host sirq_host_chk #(.MAX_SLOTS(BASE_FRAMES + 15)) u_chk (.*);

// File: tb/sirq_host_tb_top.sv
module sirq_host_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [7:0]  cfg_wr_data;
  logic [7:0]  cfg_rd_data;
  logic        sirq_in;
  logic        sirq_oe;
  logic [31:0] irq_req;
  logic        pdrv;

  int nchk = 0;
  int nerr = 0;

  always #5ns clk = ~clk;

  // open-drain shared line: low if either side pulls
  assign sirq_in = ~(sirq_oe | pdrv);

  sirq_host dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .sirq_in     (sirq_in),
    .sirq_oe     (sirq_oe),
    .irq_req     (irq_req)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] code);
    return (code == 2'd1) ? 6 : (code == 2'd2) ? 8 : 4;
  endfunction

  function automatic logic [31:0] keep_mask(input int n);
    return 32'((64'd1 << n) - 64'd1);
  endfunction

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  // Runs one cycle from an idle negedge; returns start and stop low lengths
  task automatic run_cycle(input logic [31:0] mask, input int nslots,
                           input bit periph_start, input bit poke_idle,
                           output int slen, output int plen);
    int guard = 0;
    if (periph_start || poke_idle) begin
      pdrv = 1'b1;
      @(negedge clk);
      pdrv = 1'b0;
    end
    while (!sirq_oe && guard < 200) begin guard++; @(negedge clk); end
    slen = 0;
    while (sirq_oe && slen < 40) begin slen++; @(negedge clk); end
    repeat (2) @(negedge clk);
    for (int k = 0; k < nslots; k++) begin
      pdrv = mask[k];
      @(negedge clk);
      pdrv = 1'b0;
      repeat (2) @(negedge clk);
    end
    plen = 0;
    while (sirq_oe && plen < 40) begin plen++; @(negedge clk); end
  endtask

  initial begin
    #2ms;
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int slen, plen, iter;
    logic [31:0] m;
    logic [7:0]  v;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0; pdrv = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cfg reset", cfg_rd_data, 8'h10);
    chk("R1 oe reset", sirq_oe, 0);
    chk("R1 irq reset", irq_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 disabled: line activity is ignored, nothing is driven
    for (int i = 0; i < 40; i++) begin
      pdrv = i[0] ^ i[2];
      @(negedge clk);
      chk("R3 off no drive", sirq_oe, 0);
      chk("R3 off no request", irq_req, 0);
    end
    pdrv = 1'b0;

    // R2 + R6: quiet mode selected, first cycle still host-started full width
    cfg_write(8'h90);
    chk("R2 readback", cfg_rd_data, 8'h90);
    m = 32'h0015_A5C3;
    run_cycle(m, 21, 0, 0, slen, plen);
    chk("R6 forced start width", slen, 4);
    chk("R8 quiet stop", plen, 2);
    chk("R7 slot levels", irq_req, m & keep_mask(21));

    // R5: quiet idle waits for the peripheral
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sirq_oe) break;
    end
    chk("R5 no unprompted start", sirq_oe, 0);
    for (int pw = 0; pw < 4; pw++) begin
      cfg_write(8'h00);
      v = 8'h90 | 8'(pw);
      cfg_write(v);
      chk("R2 readback", cfg_rd_data, v);
      m = 32'h1E69_0F33 >> pw;
      run_cycle(m, 21, 1, 0, slen, plen);
      chk("R5 shortened start", slen, width_of(2'(pw)) - 1);
      chk("R8 quiet stop", plen, 2);
      chk("R7 slot levels quiet", irq_req, m & keep_mask(21));
    end

    // R4/R7/R8/R9: continuous sweep over widths and frame counts
    iter = 0;
    for (int pw = 0; pw < 4; pw++) begin
      for (int f = 0; f < 3; f++) begin
        int code, n;
        code = (f == 0) ? 0 : (f == 1) ? 4 : 15;
        n    = 17 + code;
        cfg_write(8'h00);
        v = 8'hC0 | 8'(code << 2) | 8'(pw);
        cfg_write(v);
        chk("R2 readback", cfg_rd_data, v);
        m = {32'hA5C3_1E69 << iter} ^ (32'h1 << iter);
        run_cycle(m, n, 0, iter[0], slen, plen);
        chk(iter[0] ? "R9 poked start width" : "R4 start width", slen, width_of(2'(pw)));
        chk("R8 continuous stop", plen, 3);
        chk("R7 slot levels", irq_req, m & keep_mask(n));
        @(negedge clk);
        chk("R4 one idle clock", sirq_oe, 1);
        iter++;
      end
    end

    // back-to-back cycle: bits flip both ways (32 slots configured last)
    m = ~m;
    run_cycle(m, 32, 0, 0, slen, plen);
    chk("R4 start width repeat", slen, 4);
    chk("R7 slot levels repeat", irq_req, m);

    // R3 abort mid-cycle
    while (!sirq_oe) @(negedge clk);
    cfg_write(8'h4C);
    chk("R3 abort stops drive", sirq_oe, 0);
    @(negedge clk);
    chk("R3 abort clears", irq_req, 0);
    pdrv = 1'b1;
    repeat (5) @(negedge clk);
    chk("R3 off ignores line", sirq_oe, 0);
    chk("R3 off ignores line irq", irq_req, 0);
    pdrv = 1'b0;

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule